// File: doc/BRIEF.md
# Multichannel DAC Update Sequencer

This block feeds up to four DAC channels from one shared sample FIFO. The FIFO holds samples interleaved by channel, in the order set by a programmable channel list. After each output update, the sequencer reads one sample per listed entry, one entry at a time. Each sample goes into the staging register of the channel named by that entry. On the next sample-clock tick, every channel loaded in that round copies its staged value to its output register on the same edge. Output registers keep their old values while staging loads are in progress.

Only one transfer path exists, and each entry takes a fixed number of system cycles to load. A longer list therefore needs a longer gap between sample ticks. If a tick arrives before the round has finished loading, the block sets a sticky overrun flag and leaves the outputs as they were for that period. Software or upstream logic uses this flag to detect a sample rate that is too high for the configured list.

Top module: `dac_update_seq`

## Requirements
- R1: A synchronous reset sets every channel output to `IDLE_CODE` and clears `overrun`. It also restarts sequencing at list entry 0, so the first sample read after reset goes to the channel named by entry 0.
- R2: `fifoData` is valid in the same cycle whenever `fifoEmpty` is low, and a high `fifoRd` pops one word. `fifoRd` is never high while `fifoEmpty` is high. Loading stalls for as long as the FIFO stays empty.
- R3: Within a round, the k-th sample read is written to the channel held in list entry k, which occupies bits `2k+1:2k` of `chanList`. Entries may name the channels in any order. If an entry repeats a channel, the later sample overwrites the earlier one.
- R4: `chanCount` gives the number of active list entries, from 1 to 4. A value of 0 is treated as 1, and a value above 4 is treated as 4. A channel not named by an active entry keeps its output value across an update.
- R5: Outputs change only on the edge at which a `sampleTick` is accepted after a fully loaded round. All channels loaded in that round change on that same edge. At every other edge the outputs hold.
- R6: Each list entry takes two cycles to load (one FIFO read, one staging write), so a round of N entries becomes ready 2N edges after it starts. A tick on any edge up to and including the last staging write is early. A tick on any later edge is accepted.
- R7: An early tick sets `overrun` and leaves the outputs unchanged. `overrun` then stays high until `clearErr` is sampled high. If an early tick and `clearErr` arrive in the same cycle, the flag is set.
- R8: Until the first round after reset has fully loaded, every tick is early. The outputs therefore stay at `IDLE_CODE` and never show a partly loaded set.
- R9: When a tick is accepted, a new round begins at once, starting again from list entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| fifoEmpty | input | 1 | Shared sample FIFO has no data |
| fifoData | input | DATA_W | Head word of the FIFO (show-ahead) |
| fifoRd | output | 1 | Pop one word from the FIFO |
| chanList | input | NUM_CH*IDX_W | Channel list, entry k at bits k*IDX_W |
| chanCount | input | CNT_W | Number of active list entries |
| sampleTick | input | 1 | Common sample clock pulse, one cycle |
| clearErr | input | 1 | Clears the overrun flag |
| dacOut | output | NUM_CH*DATA_W | Output codes, channel c at bits c*DATA_W |
| overrun | output | 1 | Sticky flag: a tick came before the round was loaded |

## Verification
The sequencing is tried with several lists: the natural order, a permuted order, a fully reversed order, a single entry, a repeated channel, and count values below and above the legal range. Every sample carries a distinct code, so a wrong entry-to-channel mapping, a sample shifted by one, or a wrong count shows up on a specific channel. The lists that leave some channels out show whether an unlisted channel is wrongly updated. Directed runs place the tick on the last staging write and on the first ready edge, starve the FIFO partway through a round, and assert reset in the middle of a round. Together these separate the overrun boundary, stall handling and the restart of the list pointer.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

  typedef enum logic [1:0] {
    ST_READ  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READY = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // take fifo head into holding register
    logic stageWr;  // write holding register into selected staging register
    logic commit;   // copy loaded staging registers to outputs
  } seqStrobe_t;

endpackage

// File: rtl/dac_seq_ctrl.sv
module dac_seq_ctrl
  import dac_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int IDX_W  = 2,
  parameter int CNT_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    fifoEmpty,
  input  logic [NUM_CH*IDX_W-1:0] chanList,
  input  logic [CNT_W-1:0]        chanCount,
  input  logic                    sampleTick,
  input  logic                    clearErr,
  output seqStrobe_t              strobe,
  output logic [IDX_W-1:0]        stageSel,
  output logic                    fifoRd,
  output logic                    overrun
);

  seqState_t        state;
  logic [IDX_W-1:0] entryPtr;
  logic [CNT_W-1:0] effCount;
  logic [CNT_W-1:0] lastEntry;
  logic             lastWrite;

  // clamp count into 1..NUM_CH
  always_comb begin
    if (chanCount == '0)
      effCount = CNT_W'(1);
    else if (chanCount > CNT_W'(NUM_CH))
      effCount = CNT_W'(NUM_CH);
    else
      effCount = chanCount;
  end

  assign lastEntry = effCount - CNT_W'(1);
  assign lastWrite = (CNT_W'(entryPtr) == lastEntry);
  assign stageSel  = chanList[int'(entryPtr)*IDX_W +: IDX_W];

  always_comb begin
    strobe         = '0;
    strobe.capture = (state == ST_READ) && !fifoEmpty;
    strobe.stageWr = (state == ST_WRITE);
    strobe.commit  = (state == ST_READY) && sampleTick;
  end

  assign fifoRd = strobe.capture;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_READ;
      entryPtr <= '0;
    end else begin
      unique case (state)
        ST_READ: begin
          if (!fifoEmpty) state <= ST_WRITE;
        end
        ST_WRITE: begin
          if (lastWrite) begin
            entryPtr <= '0;
            state    <= ST_READY;
          end else begin
            entryPtr <= entryPtr + IDX_W'(1);
            state    <= ST_READ;
          end
        end
        ST_READY: begin
          if (sampleTick) state <= ST_READ;
        end
        default: state <= ST_READ;
      endcase
    end
  end

  // sticky late-transfer flag; a set wins over a clear
  always_ff @(posedge clk) begin
    if (rst)
      overrun <= 1'b0;
    else if (sampleTick && (state != ST_READY))
      overrun <= 1'b1;
    else if (clearErr)
      overrun <= 1'b0;
  end

endmodule

// File: rtl/dac_seq_datapath.sv
module dac_seq_datapath
  import dac_seq_pkg::*;
#(
  parameter int                NUM_CH    = 4,
  parameter int                DATA_W    = 16,
  parameter int                IDX_W     = 2,
  parameter logic [DATA_W-1:0] IDLE_CODE = '0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  seqStrobe_t               strobe,
  input  logic [IDX_W-1:0]         stageSel,
  input  logic [DATA_W-1:0]        fifoData,
  output logic [NUM_CH*DATA_W-1:0] dacOut
);

  logic [DATA_W-1:0] holdReg;

  always_ff @(posedge clk) begin
    if (rst)
      holdReg <= IDLE_CODE;
    else if (strobe.capture)
      holdReg <= fifoData;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : gen_chan
    logic [DATA_W-1:0] stageReg;
    logic [DATA_W-1:0] outReg;
    logic              loaded;
    logic              selHit;

    assign selHit = strobe.stageWr && (stageSel == IDX_W'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        stageReg <= IDLE_CODE;
        outReg   <= IDLE_CODE;
        loaded   <= 1'b0;
      end else begin
        if (selHit) stageReg <= holdReg;
        if (strobe.commit) begin
          if (loaded) outReg <= stageReg;
          loaded <= 1'b0;
        end else if (selHit) begin
          loaded <= 1'b1;
        end
      end
    end

    assign dacOut[c*DATA_W +: DATA_W] = outReg;
  end

endmodule

// File: rtl/dac_update_seq.sv
module dac_update_seq
  import dac_seq_pkg::*;
#(
  parameter int                NUM_CH    = 4,
  parameter int                DATA_W    = 16,
  parameter int                IDX_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int                CNT_W     = $clog2(NUM_CH + 1),
  parameter logic [DATA_W-1:0] IDLE_CODE = 16'h8000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fifoEmpty,
  input  logic [DATA_W-1:0]        fifoData,
  output logic                     fifoRd,
  input  logic [NUM_CH*IDX_W-1:0]  chanList,
  input  logic [CNT_W-1:0]         chanCount,
  input  logic                     sampleTick,
  input  logic                     clearErr,
  output logic [NUM_CH*DATA_W-1:0] dacOut,
  output logic                     overrun
);

  seqStrobe_t       strobe;
  logic [IDX_W-1:0] stageSel;

  dac_seq_ctrl #(
    .NUM_CH(NUM_CH), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .fifoEmpty(fifoEmpty), .chanList(chanList),
    .chanCount(chanCount), .sampleTick(sampleTick), .clearErr(clearErr),
    .strobe(strobe), .stageSel(stageSel), .fifoRd(fifoRd), .overrun(overrun)
  );

  dac_seq_datapath #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .IDX_W(IDX_W), .IDLE_CODE(IDLE_CODE)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .stageSel(stageSel),
    .fifoData(fifoData), .dacOut(dacOut)
  );

endmodule

// File: rtl/dac_update_seq_chk.sv
module dac_update_seq_chk #(
  parameter int                NUM_CH    = 4,
  parameter int                DATA_W    = 16,
  parameter logic [DATA_W-1:0] IDLE_CODE = 16'h8000
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     fifoEmpty,
  input logic                     fifoRd,
  input logic                     sampleTick,
  input logic                     clearErr,
  input logic [NUM_CH*DATA_W-1:0] dacOut,
  input logic                     overrun
);

  logic armed;  // previous cycle was out of reset
  always_ff @(posedge clk) armed <= !rst;

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dacOut == {NUM_CH{IDLE_CODE}}) && !overrun);

  assert_read_needs_data_R2: assert property (@(posedge clk) disable iff (rst)
    fifoRd |-> !fifoEmpty);

  assert_hold_without_tick_R5: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(sampleTick)) |-> $stable(dacOut));

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (overrun && !clearErr) |=> overrun);

  assert_overrun_from_tick_R7: assert property (@(posedge clk) disable iff (rst)
    (armed && $rose(overrun)) |-> $past(sampleTick));

endmodule

bind dac_update_seq dac_update_seq_chk #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .IDLE_CODE(IDLE_CODE)
) u_chk (
  .clk(clk), .rst(rst), .fifoEmpty(fifoEmpty), .fifoRd(fifoRd),
  .sampleTick(sampleTick), .clearErr(clearErr), .dacOut(dacOut),
  .overrun(overrun)
);

// File: tb/dac_update_seq_bench.sv
module dac_update_seq_bench;

  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] IDLE       = 16'h8000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fifoEmpty;
  logic [15:0] fifoData;
  logic        fifoRd;
  logic [7:0]  chanList = 8'hE4;
  logic [2:0]  chanCount = 3'd4;
  logic        sampleTick = 1'b0;
  logic        clearErr = 1'b0;
  logic [63:0] dacOut;
  logic        overrun;

  int testCount = 0;
  int failCount = 0;

  // bench model of the shared fifo
  logic [15:0] fifoMem [0:63];
  logic [5:0]  wrPtr = '0;
  logic [5:0]  rdPtr = '0;
  logic        flush = 1'b0;
  assign fifoEmpty = (rdPtr == wrPtr);
  assign fifoData  = fifoMem[rdPtr];

  always @(posedge clk) begin
    if (flush) rdPtr <= wrPtr;
    else if (fifoRd) rdPtr <= rdPtr + 6'd1;
  end

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_update_seq u_dac_update_seq (
    .clk(clk), .rst(rst), .fifoEmpty(fifoEmpty), .fifoData(fifoData),
    .fifoRd(fifoRd), .chanList(chanList), .chanCount(chanCount),
    .sampleTick(sampleTick), .clearErr(clearErr), .dacOut(dacOut),
    .overrun(overrun)
  );

  // {list[7:0], count[2:0], base[15:0]}
  localparam int NVEC = 7;
  localparam logic [26:0] VECS [NVEC] = '{
    {8'hE4, 3'd4, 16'h1000},  // natural order
    {8'hD8, 3'd3, 16'h2000},  // 0,2,1
    {8'h1B, 3'd4, 16'h3000},  // 3,2,1,0
    {8'h02, 3'd1, 16'h4000},  // single entry ch2
    {8'h01, 3'd0, 16'h5000},  // count 0 -> 1, ch1
    {8'hE4, 3'd7, 16'h6000},  // count 7 -> 4
    {8'h05, 3'd2, 16'h7000}   // ch1 twice
  };

  logic [15:0] expOut [4];

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [15:0] v);
    fifoMem[wrPtr] = v;
    wrPtr = wrPtr + 6'd1;
  endtask

  task automatic tickOnce();
    sampleTick = 1'b1;
    @(negedge clk);
    sampleTick = 1'b0;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    for (int c = 0; c < 4; c++) check(req, dacOut[c*16 +: 16], expOut[c]);
  endtask

  function automatic int clampCount(input logic [2:0] cnt);
    if (cnt == 3'd0) return 1;
    if (cnt > 3'd4) return 4;
    return int'(cnt);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    failCount++;
    testCount++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) expOut[c] = IDLE;
    waitCyc(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    checkAll("R1 reset outputs");
    check("R1 reset overrun", 16'(overrun), 16'd0);

    // R8: ticks before any preload are early, outputs stay idle
    tickOnce();
    push(16'hAAAA);  // partial round only
    waitCyc(4);
    tickOnce();
    checkAll("R8 no partial update");
    check("R7 early tick sets overrun", 16'(overrun), 16'd1);
    clearErr = 1'b1; @(negedge clk); clearErr = 1'b0;
    check("R7 clear", 16'(overrun), 16'd0);
    // finish that partial round (list E4, count 4)
    push(16'hAAAB); push(16'hAAAC); push(16'hAAAD);
    waitCyc(9);
    tickOnce();
    expOut[0] = 16'hAAAA; expOut[1] = 16'hAAAB; expOut[2] = 16'hAAAC; expOut[3] = 16'hAAAD;
    checkAll("R8 full preload commits");

    // table walk: R3 order, R4 count and unlisted hold, R5, R9
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0]  lst;
      logic [2:0]  cnt;
      logic [15:0] base;
      int          n;
      {lst, cnt, base} = VECS[v];
      n = clampCount(cnt);
      chanList  = lst;
      chanCount = cnt;
      for (int k = 0; k < n; k++) push(base + 16'(k * 16'h111));
      waitCyc(2 * n + 1);
      checkAll("R5 outputs hold while loading");
      tickOnce();
      for (int k = 0; k < n; k++) expOut[lst[k*2 +: 2]] = base + 16'(k * 16'h111);
      checkAll("R3 R4 R9 table commit");
      check("R6 no overrun when in time", 16'(overrun), 16'd0);
    end

    // R6 boundary: one entry, tick on first ready edge (edge 3)
    chanList = 8'h03; chanCount = 3'd1;
    push(16'h1111);
    waitCyc(2);
    tickOnce();
    expOut[3] = 16'h1111;
    checkAll("R6 one entry ready after two cycles");
    check("R6 one entry no overrun", 16'(overrun), 16'd0);

    // R6/R7 boundary: four entries, tick on last staging write (edge 8)
    chanList = 8'hE4; chanCount = 3'd4;
    push(16'h2220); push(16'h2221); push(16'h2222); push(16'h2223);
    waitCyc(7);
    tickOnce();
    check("R6 tick on last write is early", 16'(overrun), 16'd1);
    checkAll("R7 outputs hold on overrun");
    tickOnce();
    expOut[0] = 16'h2220; expOut[1] = 16'h2221; expOut[2] = 16'h2222; expOut[3] = 16'h2223;
    checkAll("R7 next tick commits");
    check("R7 flag sticky", 16'(overrun), 16'd1);
    // set wins over clear
    clearErr = 1'b1; sampleTick = 1'b1;
    @(negedge clk);
    clearErr = 1'b0; sampleTick = 1'b0;
    check("R7 set beats clear", 16'(overrun), 16'd1);
    clearErr = 1'b1; @(negedge clk); clearErr = 1'b0;
    check("R7 clear alone", 16'(overrun), 16'd0);

    // R2 stall: fifo runs dry mid round
    chanList = 8'h03; chanCount = 3'd2;  // entries ch3, ch0
    push(16'h3330);
    waitCyc(10);
    check("R2 stalled reads", 16'(fifoRd), 16'd0);
    tickOnce();
    check("R2 stall leads to overrun", 16'(overrun), 16'd1);
    checkAll("R2 outputs hold during stall");
    clearErr = 1'b1; @(negedge clk); clearErr = 1'b0;
    push(16'h3331);
    waitCyc(5);
    tickOnce();
    expOut[3] = 16'h3330; expOut[0] = 16'h3331;
    checkAll("R2 resumes after stall");

    // R1: reset mid round restarts at entry 0
    chanList = 8'h1B; chanCount = 3'd2;  // entries ch3, ch2
    push(16'h4440);
    waitCyc(3);
    rst = 1'b1; flush = 1'b1;
    waitCyc(2);
    rst = 1'b0; flush = 1'b0;
    for (int c = 0; c < 4; c++) expOut[c] = IDLE;
    checkAll("R1 reset mid round");
    check("R1 reset clears overrun", 16'(overrun), 16'd0);
    push(16'h5550); push(16'h5551);
    waitCyc(5);
    tickOnce();
    expOut[3] = 16'h5550; expOut[2] = 16'h5551;
    checkAll("R1 restart at entry 0");

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule